// File: doc/BRIEF.md
# Interrupt Domain Register Front-End

This block is the software-visible register file of a small interrupt domain with a parameterized number of sources (63 by default). A single-cycle bus port carries word-aligned reads and writes. The block keeps one domain configuration word, and one configuration word and one target word for each source. It also keeps one enable bit per source. Software changes the enable bits by writing a source number to a set register or a clear register, or by writing a 32-source bitmap to a clear-bitmap window.

Downstream logic evaluates pending and trigger state and picks the hart. That logic reads the stored state from flat export buses: each source's 3-bit mode field, its delegate bit, its enable bit and its 14-bit target hart index, plus the domain-wide interrupt-enable bit. An enable change is accepted only for a source whose mode field is non-zero. A read returns its data one cycle after the request. A read of an address the block does not decode is flagged for that one cycle.

Top module: `irqdom_regs`

## Requirements
- R1: After reset, dom_ie, every src_en bit, every src_mode field, every src_deleg bit, every src_hart field, rd_valid and rd_err are all zero.
- R2: A write to byte offset 0x0000 stores only data bit 8 as the interrupt-enable bit. A read of 0x0000 returns that bit in position 8 with all other bits zero, and dom_ie follows the stored bit.
- R3: Source i (1 to NUM_SRC) has a read/write configuration word at 0x0004 + (i-1)*4 that keeps all 32 bits. src_mode for source i is bits 2:0 of that word and src_deleg for source i is bit 10. Source i sits at src_mode[3*(i-1) +: 3] and at bit i-1 of src_deleg and src_en.
- R4: Source i has a read/write target word at 0x3004 + (i-1)*4 that keeps all 32 bits. src_hart[14*(i-1) +: 14] equals bits 31:18 of that word.
- R5: Writing value n to 0x1EDC sets the enable bit of source n. A read of 0x1EDC returns zero with no error.
- R6: Writing value n to 0x1FDC clears the enable bit of source n. A read of 0x1FDC returns zero with no error.
- R7: A write to 0x1F00 + 4*w, for w = 0 to ceil((NUM_SRC+1)/32)-1, clears the enable bit of source 32*w + b for every set data bit b. Reads of these words return zero with no error.
- R8: A set or clear of an enable bit has no effect when the source number is 0, when it exceeds NUM_SRC, or when the source's mode field is zero at the time of the write.
- R9: A read of any other offset, or of any offset that is not a multiple of 4, returns zero data with rd_err high. A write to such an offset changes no state.
- R10: rd_valid is high exactly in the cycle after a read request and carries that read's data. A write request produces no rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| rd_err | output | 1 | Read hit an undecoded offset |
| dom_ie | output | 1 | Domain interrupt-enable bit |
| src_mode | output | 3*NUM_SRC | Mode field of each source |
| src_deleg | output | NUM_SRC | Delegate bit of each source |
| src_en | output | NUM_SRC | Enable bit of each source |
| src_hart | output | 14*NUM_SRC | Target hart index of each source |

## Verification
The directed sequences try the enable logic in four ways: by number on active sources, with source number 0, with numbers above the top source and with all-ones, on sources whose mode is zero, and with full and single-bit bitmaps in both window words. Together these separate a bad range check from a missing mode gate and from a wrong bitmap-to-source mapping. All-ones writes to the domain word and to the target words show whether the domain write is masked and whether the hart field is sliced from the right bits. A long pseudo-random mix of reads and writes across every decoded window, the unmapped gaps and misaligned offsets is compared against the bench model on every clock. That mix exposes decode boundaries that are off by one word, and reads that return stale data.

// File: rtl/irqdom_pkg.sv
package irqdom_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_DOM,
    ACC_CFG,
    ACC_TGT,
    ACC_SETN,
    ACC_CLRN,
    ACC_CLRMAP
  } acc_kind_e;

  localparam logic [31:0] OFS_DOM    = 32'h0000_0000;
  localparam logic [31:0] OFS_CFG0   = 32'h0000_0004;
  localparam logic [31:0] OFS_SETN   = 32'h0000_1EDC;
  localparam logic [31:0] OFS_CLRMAP = 32'h0000_1F00;
  localparam logic [31:0] OFS_CLRN   = 32'h0000_1FDC;
  localparam logic [31:0] OFS_TGT0   = 32'h0000_3004;

  localparam int IE_BIT    = 8;
  localparam int MODE_W    = 3;
  localparam int DELEG_BIT = 10;
  localparam int HART_LSB  = 18;
  localparam int HART_W    = 32 - HART_LSB;

endpackage

// File: rtl/irqdom_decode.sv
module irqdom_decode
  import irqdom_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_SRC = 63,
  parameter int SRC_W   = 6,
  parameter int NWORDS  = 2,
  parameter int WORD_W  = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [SRC_W-1:0]  idx,
  output logic [WORD_W-1:0] word
);

  localparam logic [31:0] CFG_LAST = OFS_CFG0 + 32'((NUM_SRC - 1) * 4);
  localparam logic [31:0] TGT_LAST = OFS_TGT0 + 32'((NUM_SRC - 1) * 4);
  localparam logic [31:0] MAP_END  = OFS_CLRMAP + 32'(NWORDS * 4);

  logic [31:0] a;
  logic [31:0] off;
  logic [31:0] slot;

  assign a = 32'(addr);

  always_comb begin
    kind = ACC_NONE;
    off  = '0;
    if (a[1:0] == 2'b00) begin
      if (a == OFS_DOM) begin
        kind = ACC_DOM;
      end else if (a >= OFS_CFG0 && a <= CFG_LAST) begin
        kind = ACC_CFG;
        off  = a - OFS_CFG0;
      end else if (a == OFS_SETN) begin
        kind = ACC_SETN;
      end else if (a == OFS_CLRN) begin
        kind = ACC_CLRN;
      end else if (a >= OFS_CLRMAP && a < MAP_END) begin
        kind = ACC_CLRMAP;
        off  = a - OFS_CLRMAP;
      end else if (a >= OFS_TGT0 && a <= TGT_LAST) begin
        kind = ACC_TGT;
        off  = a - OFS_TGT0;
      end
    end
  end

  assign slot = off >> 2;
  assign idx  = SRC_W'(slot + 32'd1);
  assign word = WORD_W'(slot);

endmodule

// File: rtl/irqdom_src_bank.sv
module irqdom_src_bank
  import irqdom_pkg::*;
#(
  parameter int NUM_SRC = 63,
  parameter int SRC_W   = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic                      tgt_we,
  input  logic [SRC_W-1:0]          idx,
  input  logic [31:0]               wdata,
  output logic [31:0]               cfg_rd,
  output logic [31:0]               tgt_rd,
  output logic [NUM_SRC*MODE_W-1:0] mode_flat,
  output logic [NUM_SRC-1:0]        deleg,
  output logic [NUM_SRC*HART_W-1:0] hart_flat
);

  logic [NUM_SRC-1:0][31:0] cfg_q;
  logic [NUM_SRC-1:0][31:0] tgt_q;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    localparam logic [SRC_W-1:0] MY_IDX = SRC_W'(k + 1);

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[k] <= '0;
        tgt_q[k] <= '0;
      end else begin
        if (cfg_we && idx == MY_IDX) cfg_q[k] <= wdata;
        if (tgt_we && idx == MY_IDX) tgt_q[k] <= wdata;
      end
    end

    assign mode_flat[k*MODE_W +: MODE_W] = cfg_q[k][MODE_W-1:0];
    assign deleg[k]                      = cfg_q[k][DELEG_BIT];
    assign hart_flat[k*HART_W +: HART_W] = tgt_q[k][HART_LSB +: HART_W];
  end

  always_comb begin
    cfg_rd = '0;
    tgt_rd = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (idx == SRC_W'(k + 1)) begin
        cfg_rd = cfg_q[k];
        tgt_rd = tgt_q[k];
      end
    end
  end

endmodule

// File: rtl/irqdom_enable.sv
module irqdom_enable
  import irqdom_pkg::*;
#(
  parameter int NUM_SRC = 63,
  parameter int WORD_W  = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      set_we,
  input  logic                      clr_we,
  input  logic                      map_we,
  input  logic [31:0]               wdata,
  input  logic [WORD_W-1:0]         word,
  input  logic [NUM_SRC*MODE_W-1:0] mode_flat,
  output logic [NUM_SRC-1:0]        en
);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_en
    localparam int SNUM = k + 1;
    localparam int MW   = SNUM / 32;
    localparam int MB   = SNUM % 32;

    logic active;
    logic set_hit;
    logic clr_hit;

    assign active  = |mode_flat[k*MODE_W +: MODE_W];
    assign set_hit = set_we && (wdata == 32'(SNUM));
    assign clr_hit = (clr_we && (wdata == 32'(SNUM))) ||
                     (map_we && (word == WORD_W'(MW)) && wdata[MB]);

    always_ff @(posedge clk) begin
      if (rst) begin
        en[k] <= 1'b0;
      end else if (active) begin
        if (set_hit)      en[k] <= 1'b1;
        else if (clr_hit) en[k] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irqdom_regs.sv
module irqdom_regs
  import irqdom_pkg::*;
#(
  parameter int NUM_SRC = 63,
  parameter int ADDR_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [31:0]               req_wdata,
  output logic                      rd_valid,
  output logic [31:0]               rd_data,
  output logic                      rd_err,
  output logic                      dom_ie,
  output logic [NUM_SRC*MODE_W-1:0] src_mode,
  output logic [NUM_SRC-1:0]        src_deleg,
  output logic [NUM_SRC-1:0]        src_en,
  output logic [NUM_SRC*HART_W-1:0] src_hart
);

  localparam int SRC_W  = $clog2(NUM_SRC + 1);
  localparam int NWORDS = (NUM_SRC + 32) / 32;
  localparam int WORD_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  acc_kind_e         kind;
  logic [SRC_W-1:0]  idx;
  logic [WORD_W-1:0] word;
  logic              wr;
  logic              rd;
  logic [31:0]       cfg_rd;
  logic [31:0]       tgt_rd;
  logic [31:0]       rmux;
  logic              ie_q;

  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  irqdom_decode #(
    .ADDR_W (ADDR_W),
    .NUM_SRC(NUM_SRC),
    .SRC_W  (SRC_W),
    .NWORDS (NWORDS),
    .WORD_W (WORD_W)
  ) dec_i (
    .addr(req_addr),
    .kind(kind),
    .idx (idx),
    .word(word)
  );

  irqdom_src_bank #(
    .NUM_SRC(NUM_SRC),
    .SRC_W  (SRC_W)
  ) bank_i (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (wr && kind == ACC_CFG),
    .tgt_we   (wr && kind == ACC_TGT),
    .idx      (idx),
    .wdata    (req_wdata),
    .cfg_rd   (cfg_rd),
    .tgt_rd   (tgt_rd),
    .mode_flat(src_mode),
    .deleg    (src_deleg),
    .hart_flat(src_hart)
  );

  irqdom_enable #(
    .NUM_SRC(NUM_SRC),
    .WORD_W (WORD_W)
  ) en_i (
    .clk      (clk),
    .rst      (rst),
    .set_we   (wr && kind == ACC_SETN),
    .clr_we   (wr && kind == ACC_CLRN),
    .map_we   (wr && kind == ACC_CLRMAP),
    .wdata    (req_wdata),
    .word     (word),
    .mode_flat(src_mode),
    .en       (src_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q <= 1'b0;
    end else if (wr && kind == ACC_DOM) begin
      ie_q <= req_wdata[IE_BIT];
    end
  end

  assign dom_ie = ie_q;

  always_comb begin
    unique case (kind)
      ACC_DOM: begin
        rmux         = '0;
        rmux[IE_BIT] = ie_q;
      end
      ACC_CFG: rmux = cfg_rd;
      ACC_TGT: rmux = tgt_rd;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      rd_err   <= rd && (kind == ACC_NONE);
      rd_data  <= rd ? rmux : '0;
    end
  end

endmodule

// File: rtl/irqdom_regs_chk.sv
module irqdom_regs_chk
  import irqdom_pkg::*;
#(
  parameter int NUM_SRC = 63,
  parameter int ADDR_W  = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      req_valid,
  input logic                      req_write,
  input logic [ADDR_W-1:0]         req_addr,
  input logic                      rd_valid,
  input logic [31:0]               rd_data,
  input logic                      rd_err,
  input logic                      dom_ie,
  input logic [NUM_SRC*MODE_W-1:0] src_mode,
  input logic [NUM_SRC-1:0]        src_en
);

  // R10
  read_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);

  // R10
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rd_valid);

  // R9
  err_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> (rd_valid && rd_data == 32'd0));

  // R9
  misaligned_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_addr[1:0] != 2'b00) |=> rd_err);

  // R2
  ie_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> $stable(dom_ie));

  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> $stable(src_en));

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> $stable(src_mode));

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_gate
    // R8
    inactive_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (src_mode[k*MODE_W +: MODE_W] == '0) |=> $stable(src_en[k]));
  end

endmodule

bind irqdom_regs irqdom_regs_chk #(
  .NUM_SRC(NUM_SRC),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .rd_err   (rd_err),
  .dom_ie   (dom_ie),
  .src_mode (src_mode),
  .src_en   (src_en)
);

// File: tb/irqdom_regs_tb_top.sv
`timescale 1ns/1ps
module irqdom_regs_tb_top;

  localparam int N  = 63;
  localparam int AW = 16;
  localparam int HW = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [31:0]   req_wdata = '0;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic          rd_err;
  logic          dom_ie;
  logic [N*3-1:0]  src_mode;
  logic [N-1:0]    src_deleg;
  logic [N-1:0]    src_en;
  logic [N*HW-1:0] src_hart;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  irqdom_regs #(.NUM_SRC(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_err(rd_err), .dom_ie(dom_ie), .src_mode(src_mode),
    .src_deleg(src_deleg), .src_en(src_en), .src_hart(src_hart)
  );

  // reference model state
  logic [31:0] m_cfg [1:N];
  logic [31:0] m_tgt [1:N];
  bit          m_en  [1:N];
  bit          m_ie;
  bit          e_rv, e_err;
  logic [31:0] e_rd;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit mode_on(int s);
    return m_cfg[s][2:0] != 3'd0;
  endfunction

  function automatic void model_read(logic [AW-1:0] a, output bit err, output logic [31:0] d);
    int ai;
    ai = int'(a);
    err = 0; d = 0;
    if (ai % 4 != 0) err = 1;
    else if (ai == 0) d = {23'd0, m_ie, 8'd0};
    else if (ai >= 4 && ai <= 4 + (N-1)*4) d = m_cfg[(ai-4)/4 + 1];
    else if (ai >= 'h3004 && ai <= 'h3004 + (N-1)*4) d = m_tgt[(ai-'h3004)/4 + 1];
    else if (ai == 'h1EDC || ai == 'h1FDC || ai == 'h1F00 || ai == 'h1F04) d = 0;
    else err = 1;
  endfunction

  function automatic void model_write(logic [AW-1:0] a, logic [31:0] d);
    int ai;
    ai = int'(a);
    if (ai % 4 != 0) return;
    if (ai == 0) m_ie = d[8];
    else if (ai >= 4 && ai <= 4 + (N-1)*4) m_cfg[(ai-4)/4 + 1] = d;
    else if (ai >= 'h3004 && ai <= 'h3004 + (N-1)*4) m_tgt[(ai-'h3004)/4 + 1] = d;
    else if (ai == 'h1EDC || ai == 'h1FDC) begin
      if (d >= 1 && d <= N && mode_on(int'(d))) m_en[int'(d)] = (ai == 'h1EDC);
    end else if (ai == 'h1F00 || ai == 'h1F04) begin
      for (int b = 0; b < 32; b++) begin
        int s;
        s = ((ai - 'h1F00) / 4) * 32 + b;
        if (d[b] && s >= 1 && s <= N && mode_on(s)) m_en[s] = 0;
      end
    end
  endfunction

  task automatic compare_all();
    check("R10", "rd_valid", 32'(rd_valid), 32'(e_rv));
    check("R9", "rd_err", 32'(rd_err), 32'(e_err));
    check("R10", "rd_data", rd_data, e_rd);
    check("R2", "dom_ie", 32'(dom_ie), 32'(m_ie));
    for (int s = 1; s <= N; s++) begin
      check("R5/R6/R7/R8", $sformatf("src_en[%0d]", s), 32'(src_en[s-1]), 32'(m_en[s]));
      check("R3", $sformatf("src_mode[%0d]", s), 32'(src_mode[3*(s-1) +: 3]), 32'(m_cfg[s][2:0]));
      check("R3", $sformatf("src_deleg[%0d]", s), 32'(src_deleg[s-1]), 32'(m_cfg[s][10]));
      check("R4", $sformatf("src_hart[%0d]", s), 32'(src_hart[HW*(s-1) +: HW]), 32'(m_tgt[s][31:18]));
    end
  endtask

  task automatic access(bit v, bit w, logic [AW-1:0] a, logic [31:0] d);
    bit          er;
    logic [31:0] rv;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    model_read(a, er, rv);
    e_rv  = v && !w;
    e_err = e_rv && er;
    e_rd  = e_rv ? rv : 32'd0;
    if (v && w) model_write(a, d);
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d); access(1, 1, a, d); endtask
  task automatic rdr(logic [AW-1:0] a); access(1, 0, a, 0); endtask

  task automatic expect_rd(string tag, logic [31:0] exp, bit exp_err);
    check(tag, "directed rd_data", rd_data, exp);
    check(tag, "directed rd_err", 32'(rd_err), 32'(exp_err));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    for (int s = 1; s <= N; s++) begin m_cfg[s] = 0; m_tgt[s] = 0; m_en[s] = 0; end
    m_ie = 0; e_rv = 0; e_err = 0; e_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1 reset state
    check("R1", "dom_ie", 32'(dom_ie), 0);
    check("R1", "src_en", 32'(|src_en), 0);
    check("R1", "src_mode", 32'(|src_mode), 0);
    check("R1", "src_deleg", 32'(|src_deleg), 0);
    check("R1", "src_hart", 32'(|src_hart), 0);
    check("R1", "rd_valid", 32'(rd_valid), 0);
    check("R1", "rd_err", 32'(rd_err), 0);

    // R2 only bit 8 kept
    wr(16'h0000, 32'hFFFF_FFFF);
    rdr(16'h0000); expect_rd("R2", 32'h0000_0100, 0);
    check("R2", "dom_ie set", 32'(dom_ie), 1);
    wr(16'h0000, 32'hFFFF_FEFF);
    check("R2", "dom_ie cleared", 32'(dom_ie), 0);

    // R3 configuration words
    wr(16'h0004, 32'h0000_0004);             // source 1 rising mode
    wr(16'h00F8, 32'hA5A5_0406);             // source 62, deleg set, mode 6
    wr(16'h00FC, 32'h0000_0007);             // source 63
    wr(16'h00A0, 32'h0000_0400);             // source 40, mode 0, deleg set
    rdr(16'h00F8); expect_rd("R3", 32'hA5A5_0406, 0);
    check("R3", "src_deleg[62]", 32'(src_deleg[61]), 1);
    check("R3", "src_mode[63]", 32'(src_mode[3*62 +: 3]), 7);

    // R4 target words
    wr(16'h3004 + 16'(4*4), 32'hFFFF_C000);   // source 5
    check("R4", "hart[5]", 32'(src_hart[HW*4 +: HW]), 32'h3FFF);
    wr(16'h30FC, 32'h0004_FFFF);              // source 63
    check("R4", "hart[63]", 32'(src_hart[HW*62 +: HW]), 1);
    rdr(16'h30FC); expect_rd("R4", 32'h0004_FFFF, 0);

    // R5 set by number
    wr(16'h1EDC, 1); wr(16'h1EDC, 62); wr(16'h1EDC, 63);
    check("R5", "en[1]", 32'(src_en[0]), 1);
    check("R5", "en[63]", 32'(src_en[62]), 1);
    rdr(16'h1EDC); expect_rd("R5", 0, 0);

    // R8 ignored cases
    wr(16'h1EDC, 40);
    check("R8", "en[40] inactive", 32'(src_en[39]), 0);
    wr(16'h1EDC, 0); wr(16'h1EDC, 64); wr(16'h1EDC, 32'hFFFF_FFFF);
    wr(16'h1EDC, 32'h0000_0101);
    check("R8", "en unchanged", 32'(src_en), 32'(src_en));
    wr(16'h0004, 0);                          // source 1 inactive now
    wr(16'h1FDC, 1);
    check("R8", "en[1] kept when inactive", 32'(src_en[0]), 1);
    wr(16'h0004, 4);

    // R6 clear by number
    wr(16'h1FDC, 62);
    check("R6", "en[62]", 32'(src_en[61]), 0);
    rdr(16'h1FDC); expect_rd("R6", 0, 0);

    // R7 bitmap clears
    for (int s = 2; s <= 33; s++) wr(16'(4*s), 32'd5);
    for (int s = 2; s <= 33; s++) wr(16'h1EDC, 32'(s));
    wr(16'h1F04, 32'h8000_0001);              // sources 32 and 63
    check("R7", "en[32]", 32'(src_en[31]), 0);
    check("R7", "en[63]", 32'(src_en[62]), 0);
    check("R7", "en[33] kept", 32'(src_en[32]), 1);
    wr(16'h1F00, 32'hFFFF_FFFF);
    check("R7", "en[1..31]", 32'(src_en[30:0]), 0);
    rdr(16'h1F04); expect_rd("R7", 0, 0);

    // R9 unmapped and misaligned
    rdr(16'h1F08); expect_rd("R9", 0, 1);
    rdr(16'h0006); expect_rd("R9", 0, 1);
    rdr(16'h0100); expect_rd("R9", 0, 1);
    rdr(16'h3100); expect_rd("R9", 0, 1);
    wr(16'h0100, 32'hFFFF_FFFF);
    wr(16'h0005, 32'hFFFF_FFFF);
    rdr(16'h0004); expect_rd("R9", 32'd4, 0);

    // R10 no response for writes
    wr(16'h0000, 0);
    check("R10", "no rd_valid on write", 32'(rd_valid), 0);

    // mixed pseudo-random traffic, compared every clock
    x = 32'h1234_5677;
    for (int i = 0; i < 1500; i++) begin
      logic [AW-1:0] a;
      logic [31:0]   d;
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      d = {x[7:0], x[31:8]};
      case (x[3:0])
        0, 1:   a = 16'(4 + 4 * (x[13:8] % 63));
        2:      a = 16'(16'h3004 + 4 * (x[13:8] % 63));
        3, 4:   begin a = 16'h1EDC; d = 32'(x[14:8]); end
        5:      begin a = 16'h1FDC; d = 32'(x[14:8]); end
        6:      a = x[8] ? 16'h1F04 : 16'h1F00;
        7:      a = 16'h0000;
        8:      a = 16'(x[23:8]);
        9:      a = 16'(16'h1F00 + 4 * x[10:8]);
        10:     a = 16'(16'h00FC + 4 * x[9:8]);
        default:a = 16'(4 + 4 * (x[13:8] % 64) + 16'(x[16]));
      endcase
      access(x[20] | x[21], x[22] | x[23], a, d);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule